// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block counts video scanlines downward and raises a level interrupt toward the CPU when the count reaches zero. Software programs it through four write-only commands on the cartridge write port. One command sets an 8-bit reload value. One asks for a reload at the next line. The other two arm the interrupt, or disarm it and clear it at the same time.

Each line the counter is told about arrives as a one-cycle `line_tick`. A tick is honoured only while the 2-bit bank-switching personality input selects value 1; otherwise the counter ignores it. When a tick arrives, the counter either reloads or decrements. The zero test is made on the value after that update, so a reload value of zero fires on every honoured line. The interrupt line is registered and stays high until software acknowledges it or reset is applied.

Top module: `scanline_irq_counter`

## Requirements
- R1: A synchronous active-high `rst` clears the reload value, the count, the reload request, the arm flag and `irq`. `irq` reads 0 on the first clock after reset.
- R2: A write whose address ANDed with 0xE001 equals 0xC000 stores `cpu_data` as the reload value. Mirrored addresses such as 0xDFFE behave the same way.
- R3: A write whose masked address equals 0xC001 sets the reload request and does not change the count.
- R4: A write whose masked address equals 0xE000 clears the arm flag and drops `irq` on the next clock, even when a zero hit happens in the same cycle.
- R5: A write whose masked address equals 0xE001 sets the arm flag. The flag applies from the following cycle, so a zero hit in the same cycle as this write does not raise `irq`.
- R6: On an honoured tick, if the count is zero or a reload is requested, the count takes the reload value and the request clears. Otherwise the count decreases by one.
- R7: If the count after an honoured tick is zero and the block is armed, `irq` goes high on the clock edge that performs the update.
- R8: Ticks are ignored unless `mode_sel` equals 2'b01.
- R9: Once high, `irq` stays high until a disarm write (R4) or reset. Further hits and other writes leave it high.
- R10: When a tick and a write meet in the same cycle, the tick is applied first. It uses the previous reload value, and a reload request written in that cycle survives for the next tick.
- R11: Writes whose masked address matches none of the four command codes have no effect. Cycles without `cpu_wr` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | One-cycle write strobe |
| line_tick | input | 1 | One-cycle scanline event |
| mode_sel | input | 2 | Bank-switching personality; ticks count only at 2'b01 |
| irq | output | 1 | Level interrupt request |

## Verification
Two functions can fall in the same cycle: a scanline tick and a command write. The bench provokes this by driving `line_tick` together with a reload-request write, with a reload-value write, with a disarm write on the cycle the count reaches zero, and with an arm write on a zero hit. A behavioural reference model applies the tick first and the write second, and its `irq` is compared with the design's on every clock. Any wrong ordering therefore shows up as an `irq` edge that comes too early, comes too late, or is missing.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int MODE_W  = 2;
    localparam logic [ADDR_W-1:0] CMD_MASK     = 16'hE001;
    localparam logic [ADDR_W-1:0] CODE_LATCH   = 16'hC000;
    localparam logic [ADDR_W-1:0] CODE_RELOAD  = 16'hC001;
    localparam logic [ADDR_W-1:0] CODE_DISARM  = 16'hE000;
    localparam logic [ADDR_W-1:0] CODE_ARM     = 16'hE001;
    localparam logic [MODE_W-1:0] MODE_ACTIVE  = 2'b01;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_LATCH,
        CMD_RELOAD,
        CMD_DISARM,
        CMD_ARM
    } cmd_e;

    typedef struct packed {
        cmd_e              cmd;
        logic [DATA_W-1:0] data;
    } cmd_t;

    function automatic cmd_e decode_cmd(input logic wr, input logic [ADDR_W-1:0] addr);
        logic [ADDR_W-1:0] m;
        m = addr & CMD_MASK;
        if (!wr)                    return CMD_NONE;
        else if (m == CODE_LATCH)   return CMD_LATCH;
        else if (m == CODE_RELOAD)  return CMD_RELOAD;
        else if (m == CODE_DISARM)  return CMD_DISARM;
        else if (m == CODE_ARM)     return CMD_ARM;
        else                        return CMD_NONE;
    endfunction
endpackage

// File: rtl/sli_cmd_decode.sv
module sli_cmd_decode
    import scanline_irq_pkg::*;
(
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output cmd_t              cmd
);
    always_comb begin
        cmd.cmd  = decode_cmd(wr, addr);
        cmd.data = data;
    end
endmodule

// File: rtl/sli_line_counter.sv
module sli_line_counter
    import scanline_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_t cmd,
    input  logic tick_act,
    output logic hit
);
    logic [DATA_W-1:0] latch_q, cnt_q, cnt_d;
    logic              rld_q,  rld_d;

    always_comb begin
        cnt_d = cnt_q;
        rld_d = rld_q;
        hit   = 1'b0;
        if (tick_act) begin
            if (cnt_q == '0 || rld_q) begin
                cnt_d = latch_q;
                rld_d = 1'b0;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
            hit = (cnt_d == '0);
        end
        if (cmd.cmd == CMD_RELOAD) rld_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            cnt_q   <= '0;
            rld_q   <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            rld_q <= rld_d;
            if (cmd.cmd == CMD_LATCH) latch_q <= cmd.data;
        end
    end

    // R3: a reload request alone leaves the count alone
    a_r3_request_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (cmd.cmd == CMD_RELOAD && !tick_act) |=> $stable(cnt_q));
    // R6: decrement path
    a_r6_decrement: assert property (@(posedge clk) disable iff (rst)
        (tick_act && cnt_q != '0 && !rld_q) |=> (cnt_q == $past(cnt_q) - 8'd1));
    // R6: reload path takes the earlier reload value and drops the request
    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
        (tick_act && (cnt_q == '0 || rld_q) && cmd.cmd != CMD_RELOAD)
        |=> (cnt_q == $past(latch_q) && !rld_q));
    // R8: without an honoured tick the count does not move
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !tick_act |=> $stable(cnt_q));
    // R10: a request written together with a tick survives it
    a_r10_request_survives: assert property (@(posedge clk) disable iff (rst)
        (tick_act && cmd.cmd == CMD_RELOAD) |=> rld_q);
endmodule

// File: rtl/sli_irq_gate.sv
module sli_irq_gate
    import scanline_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_t cmd,
    input  logic hit,
    output logic irq
);
    logic arm_q, irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (cmd.cmd == CMD_DISARM) begin
                arm_q <= 1'b0;
                irq_q <= 1'b0;
            end else begin
                if (cmd.cmd == CMD_ARM) arm_q <= 1'b1;
                if (hit && arm_q)       irq_q <= 1'b1;
            end
        end
    end

    assign irq = irq_q;

    // R4: disarm drops the line and the arm flag
    a_r4_disarm_clears: assert property (@(posedge clk) disable iff (rst)
        (cmd.cmd == CMD_DISARM) |=> (!irq_q && !arm_q));
    // R9: the line is sticky
    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_q && cmd.cmd != CMD_DISARM) |=> irq_q);
    // R5: the line rises only from an armed state
    a_r5_rise_needs_arm: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(arm_q));
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
    import scanline_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_wr,
    input  logic              line_tick,
    input  logic [MODE_W-1:0] mode_sel,
    output logic              irq
);
    cmd_t cmd;
    logic tick_act;
    logic hit;

    assign tick_act = line_tick && (mode_sel == MODE_ACTIVE);

    sli_cmd_decode u_dec (
        .wr   (cpu_wr),
        .addr (cpu_addr),
        .data (cpu_data),
        .cmd  (cmd)
    );

    sli_line_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .tick_act (tick_act),
        .hit      (hit)
    );

    sli_irq_gate u_irq (
        .clk (clk),
        .rst (rst),
        .cmd (cmd),
        .hit (hit),
        .irq (irq)
    );

    // R1: the line is low right after reset
    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> !irq);
    // R8: an ignored tick cannot produce a zero hit
    a_r8_no_hit_inactive: assert property (@(posedge clk) disable iff (rst)
        (mode_sel != MODE_ACTIVE) |-> !hit);
endmodule

// File: tb/test_scanline_irq_counter.sv
module test_scanline_irq_counter;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_data;
    logic        cpu_wr;
    logic        line_tick;
    logic [1:0]  mode_sel;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    string cur_req = "R1";

    int m_latch, m_cnt, m_rld, m_arm, m_irq;

    always #5 clk = ~clk;

    scanline_irq_counter i_scanline_irq_counter (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .line_tick(line_tick), .mode_sel(mode_sel), .irq(irq)
    );

    // behavioural reference: tick first, then the write
    always @(posedge clk) begin
        int code;
        int arm_old;
        int hit;
        if (rst) begin
            m_latch = 0; m_cnt = 0; m_rld = 0; m_arm = 0; m_irq = 0;
        end else begin
            arm_old = m_arm;
            hit = 0;
            if (line_tick && mode_sel == 2'b01) begin
                if (m_cnt == 0 || m_rld != 0) begin
                    m_cnt = m_latch;
                    m_rld = 0;
                end else begin
                    m_cnt = m_cnt - 1;
                end
                hit = (m_cnt == 0);
            end
            if (hit != 0 && arm_old != 0) m_irq = 1;
            if (cpu_wr) begin
                code = int'(cpu_addr & 16'hE001);
                if (code == 'hC000) m_latch = int'(cpu_data);
                else if (code == 'hC001) m_rld = 1;
                else if (code == 'hE000) begin m_arm = 0; m_irq = 0; end
                else if (code == 'hE001) m_arm = 1;
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            summary();
        end
    end

    task automatic compare();
        n_cmp++;
        if (irq !== m_irq[0]) begin
            n_bad++;
            $display("FAIL %s: irq actual %b expected %0d (cycle %0d)", cur_req, irq, m_irq, cyc);
        end
    endtask

    task automatic step(input logic wr, input logic [15:0] a, input logic [7:0] d, input logic tk);
        cpu_wr = wr; cpu_addr = a; cpu_data = d; line_tick = tk;
        @(posedge clk);
        @(negedge clk);
        compare();
        cpu_wr = 1'b0; line_tick = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        step(1'b1, a, d, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 16'h0000, 8'h00, 1'b1);
            step(1'b0, 16'h0000, 8'h00, 1'b0);
        end
    endtask

    initial begin
        rst = 1'b1; cpu_wr = 1'b0; cpu_addr = '0; cpu_data = '0;
        line_tick = 1'b0; mode_sel = 2'b01;
        @(negedge clk); @(negedge clk);
        compare();                      // R1 reset state
        rst = 1'b0;
        cur_req = "R1"; ticks(3);       // unarmed, count zero
        cur_req = "R5"; wr(16'hE001, 8'h00);
        cur_req = "R7"; ticks(1);       // latch 0 -> hit at once
        cur_req = "R4"; wr(16'hE000, 8'h00);
        cur_req = "R2"; wr(16'hC000, 8'd3);
        cur_req = "R3"; wr(16'hC001, 8'h00);
        cur_req = "R5"; wr(16'hE001, 8'h00);
        cur_req = "R6"; ticks(4);       // 3,2,1,0 -> irq
        cur_req = "R9"; ticks(2); wr(16'hC001, 8'h00); wr(16'hE001, 8'h00); ticks(1);
        cur_req = "R4"; wr(16'hE000, 8'h00);
        cur_req = "R2"; wr(16'hDFFE, 8'd2);      // mirrored latch write
        cur_req = "R11"; wr(16'h8000, 8'd9); wr(16'hA001, 8'd9); wr(16'h6000, 8'd9);
        step(1'b0, 16'hC000, 8'd7, 1'b0);         // no strobe
        cur_req = "R5"; wr(16'hE001, 8'h00);
        cur_req = "R6"; ticks(5);
        cur_req = "R8"; wr(16'hE000, 8'h00); wr(16'hE001, 8'h00);
        mode_sel = 2'b10; ticks(6);
        mode_sel = 2'b11; ticks(2);
        mode_sel = 2'b00; ticks(2);
        mode_sel = 2'b01; ticks(3);
        cur_req = "R10";
        wr(16'hE000, 8'h00); wr(16'hE001, 8'h00);
        wr(16'hC000, 8'd4);
        step(1'b1, 16'hC001, 8'h00, 1'b1);   // tick with request write
        ticks(1);
        step(1'b1, 16'hC000, 8'd1, 1'b1);    // tick with latch write
        ticks(5);
        cur_req = "R4";
        wr(16'hE000, 8'h00); wr(16'hE001, 8'h00);
        wr(16'hC000, 8'd1); wr(16'hC001, 8'h00);
        ticks(1);                             // count 1
        step(1'b1, 16'hE000, 8'h00, 1'b1);   // disarm on hit cycle
        step(1'b0, 16'h0, 8'h0, 1'b0);
        cur_req = "R5";
        wr(16'hC001, 8'h00);
        ticks(1);
        step(1'b1, 16'hE001, 8'h00, 1'b1);   // arm on hit cycle
        step(1'b0, 16'h0, 8'h0, 1'b0);
        ticks(2);
        cur_req = "R1";
        rst = 1'b1; step(1'b0, 16'h0, 8'h0, 1'b0);
        rst = 1'b0; ticks(2);
        summary();
    end
endmodule